// File: doc/BRIEF.md
# DMA channel transfer sequencer

A single DMA channel that moves data items between a peripheral-side address and a memory-side address. Software programs both base addresses, an item count and a control word through a small register-style write port. It then sets the enable bit. The channel asks an external arbiter for the bus and waits for a grant. For each item it does one single-beat read from the current source address and one single-beat write to the current destination address, then decrements the remaining count.

In peripheral mode each item needs one request from the peripheral and is acknowledged through a request/acknowledge handshake. In memory-to-memory mode items run back to back with no request. Each side has its own item width and its own increment enable. When the two widths differ, the item is zero-extended or truncated. Circular mode reloads the count and both pointers at the end of a round. The channel reports progress with single-cycle half, done and error pulses.

Top module: `dma_chan_seq`

## Requirements
- R1: Config writes use `cfg_sel_i`: 0 = peripheral base, 1 = memory base, 2 = item count (low 16 bits), 3 = control. Control bits are: [0] enable, [1] direction, [2] peripheral increment, [3] memory increment, [5:4] peripheral width, [7:6] memory width, [8] circular, [9] memory-to-memory. Each item is a read cycle from the source followed by a write cycle to the destination. After the write, `remain_o` drops by one.
- R2: Direction 0 makes the peripheral address the source and the memory address the destination. Direction 1 reverses this.
- R3: Width code 0/1/2 means 1/2/4 bytes. After each item, a side with increment on advances by its own width in bytes. A side with increment off stays at its base.
- R4: The written data is the read data masked to the source width, then masked to the destination width. This gives zero-extension when the destination is wider and truncation when it is narrower.
- R5: In normal mode the channel clears its enable and pulses `done_o` once after the last item. Enabling with a count of zero pulses `done_o` with no bus cycle, and the enable stays low.
- R6: In circular mode, when the count reaches zero, the count and both pointers reload from their programmed values. `done_o` pulses and transfers go on while the channel is enabled.
- R7: Memory-to-memory mode runs without `preq_i`. If circular is also set, circular is ignored and the channel stops after one round.
- R8: In peripheral mode, one item is moved per request. `pack_o` rises as the access starts and falls once `preq_i` is low after the write. No bus cycle happens without a request.
- R9: If the source or destination is not aligned to its own width, the channel raises a one-cycle `err_o` pulse. It then clears enable and makes no bus cycle.
- R10: A bus error response during a read or write aborts the transfer. It pulses `err_o` and clears enable. Items already written stay written and `remain_o` holds its value.
- R11: While enabled, all config writes are ignored, except a control write with bit 0 low, which disables the channel.
- R12: `half_o` pulses once per round, after the item that leaves `remain_o` equal to the programmed count divided by two (rounded down).
- R13: `arb_req_o` is high while the channel waits for an access. No bus cycle starts until `arb_gnt_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_sel_i | input | 2 | Config register select |
| cfg_wdata_i | input | AW | Config write data |
| chan_en_o | output | 1 | Channel enabled |
| remain_o | output | CW | Items remaining in the round |
| arb_req_o | output | 1 | Bus request to the arbiter |
| arb_gnt_i | input | 1 | Grant from the arbiter |
| preq_i | input | 1 | Peripheral transfer request |
| pack_o | output | 1 | Peripheral acknowledge |
| bus_req_o | output | 1 | Bus access valid |
| bus_we_o | output | 1 | Bus write (1) or read (0) |
| bus_addr_o | output | AW | Bus byte address |
| bus_size_o | output | 2 | Access width code |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data |
| bus_ready_i | input | 1 | Access completes this cycle |
| bus_err_i | input | 1 | Error response, valid with ready |
| half_o | output | 1 | Half-round pulse |
| done_o | output | 1 | Round-complete pulse |
| err_o | output | 1 | Transfer-error pulse |

## Verification
The hardest state to reach from the ports is the circular wrap on a peripheral channel, which needs several handshaked requests in a row. The wrap must reload both pointers while half and done pulses interleave across rounds. The bench drives five single-item handshakes into a two-item circular round, so the scoreboard sees the addresses fold back twice. It then disables the channel through the one control write still accepted while enabled. A bus error in the middle of a round is reached by arming the bus model to fault on one exact read address. This shows that the first item stays written and the count freezes.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {ST_IDLE, ST_ARB, ST_RD, ST_WR, ST_ACKW} st_e;

  localparam logic [1:0] SEL_PBASE = 2'd0;
  localparam logic [1:0] SEL_MBASE = 2'd1;
  localparam logic [1:0] SEL_CNT   = 2'd2;
  localparam logic [1:0] SEL_CTRL  = 2'd3;

  // control word bits [9:1]; bit 0 is enable
  typedef struct packed {
    logic       m2m;
    logic       circ;
    logic [1:0] mwid;
    logic [1:0] pwid;
    logic       minc;
    logic       pinc;
    logic       dir;
  } ctrl_t;

  function automatic logic [2:0] wid_bytes(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] wid_mask(input logic [1:0] w);
    case (w)
      2'd0:    return 32'h0000_00ff;
      2'd1:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic is_aligned(input logic [1:0] a, input logic [1:0] w);
    case (w)
      2'd0:    return 1'b1;
      2'd1:    return ~a[0];
      default: return (a == 2'b00);
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_cfg.sv
module dma_chan_cfg
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          clr_en_i,
  output logic [AW-1:0] pbase_o,
  output logic [AW-1:0] mbase_o,
  output logic [CW-1:0] cnt_o,
  output ctrl_t         ctrl_o,
  output logic          en_o,
  output logic          start_o,
  output logic          zero_o
);

  logic [AW-1:0] pbase_q, mbase_q;
  logic [CW-1:0] cnt_q;
  ctrl_t         ctrl_q;
  logic          en_q, start_q;
  logic          ctrl_wr;

  assign ctrl_wr = we_i && (sel_i == SEL_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pbase_q <= '0;
      mbase_q <= '0;
      cnt_q   <= '0;
      ctrl_q  <= '0;
      en_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (clr_en_i) en_q <= 1'b0;
      if (we_i) begin
        if (!en_q) begin
          case (sel_i)
            SEL_PBASE: pbase_q <= wdata_i;
            SEL_MBASE: mbase_q <= wdata_i;
            SEL_CNT:   cnt_q   <= wdata_i[CW-1:0];
            default: begin
              ctrl_q <= ctrl_t'(wdata_i[9:1]);
              if (wdata_i[0] && cnt_q != '0) begin
                en_q    <= 1'b1;
                start_q <= 1'b1;
              end
            end
          endcase
        end else if (ctrl_wr && !wdata_i[0]) begin
          en_q <= 1'b0;
        end
      end
    end
  end

  // enable with an empty count: finish at once
  assign zero_o  = ctrl_wr && !en_q && wdata_i[0] && (cnt_q == '0);
  assign pbase_o = pbase_q;
  assign mbase_o = mbase_q;
  assign cnt_o   = cnt_q;
  assign ctrl_o  = ctrl_q;
  assign en_o    = en_q;
  assign start_o = start_q;

  a_r11_pbase_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(pbase_q));
  a_r11_cnt_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(cnt_q));

endmodule

// File: rtl/dma_chan_ptr.sv
module dma_chan_ptr
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          inc_i,
  input  logic [1:0]    wid_i,
  output logic [AW-1:0] cur_o
);

  logic [AW-1:0] cur_q, step;

  assign step = inc_i ? AW'(wid_bytes(wid_i)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cur_q <= '0;
    else if (load_i)  cur_q <= base_i;
    else if (adv_i)   cur_q <= cur_q + step;
  end

  assign cur_o = cur_q;

  a_r3_fixed_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(cur_q));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  output logic          chan_en_o,
  output logic [CW-1:0] remain_o,
  output logic          arb_req_o,
  input  logic          arb_gnt_i,
  input  logic          preq_i,
  output logic          pack_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ready_i,
  input  logic          bus_err_i,
  output logic          half_o,
  output logic          done_o,
  output logic          err_o
);

  localparam int unsigned NSIDE = 2; // 0 peripheral, 1 memory

  logic [AW-1:0] pbase, mbase;
  logic [CW-1:0] cnt_prog;
  ctrl_t         ctrl;
  logic          en, start, zero_done;
  logic          clr_en, load_p, adv;

  dma_chan_cfg #(.AW(AW), .CW(CW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .wdata_i  (cfg_wdata_i),
    .clr_en_i (clr_en),
    .pbase_o  (pbase),
    .mbase_o  (mbase),
    .cnt_o    (cnt_prog),
    .ctrl_o   (ctrl),
    .en_o     (en),
    .start_o  (start),
    .zero_o   (zero_done)
  );

  logic [AW-1:0] side_base [NSIDE];
  logic          side_inc  [NSIDE];
  logic [1:0]    side_wid  [NSIDE];
  logic [AW-1:0] side_cur  [NSIDE];

  assign side_base[0] = pbase;
  assign side_base[1] = mbase;
  assign side_inc[0]  = ctrl.pinc;
  assign side_inc[1]  = ctrl.minc;
  assign side_wid[0]  = ctrl.pwid;
  assign side_wid[1]  = ctrl.mwid;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_chan_ptr #(.AW(AW)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .base_i (side_base[g]),
      .load_i (load_p),
      .adv_i  (adv),
      .inc_i  (side_inc[g]),
      .wid_i  (side_wid[g]),
      .cur_o  (side_cur[g])
    );
  end

  logic          src_sel, dst_sel;
  logic [AW-1:0] src_addr, dst_addr;
  logic [1:0]    src_wid, dst_wid;
  logic          circ_eff, trigger, addr_ok;

  assign src_sel  = ctrl.dir;
  assign dst_sel  = ~ctrl.dir;
  assign src_addr = side_cur[src_sel];
  assign dst_addr = side_cur[dst_sel];
  assign src_wid  = side_wid[src_sel];
  assign dst_wid  = side_wid[dst_sel];
  assign circ_eff = ctrl.circ & ~ctrl.m2m;
  assign trigger  = ctrl.m2m | preq_i;
  assign addr_ok  = is_aligned(src_addr[1:0], src_wid) && is_aligned(dst_addr[1:0], dst_wid);

  st_e           st_q, st_n;
  logic [CW-1:0] rem_q, rem_n, rem_dec;
  logic [DW-1:0] data_q;
  logic          pack_q, half_q, done_q, err_q;
  logic          ack_set, ack_clr, half_c, done_c, err_c;

  assign rem_dec = rem_q - CW'(1);

  always_comb begin
    st_n    = st_q;
    rem_n   = rem_q;
    clr_en  = 1'b0;
    load_p  = 1'b0;
    adv     = 1'b0;
    ack_set = 1'b0;
    ack_clr = 1'b0;
    half_c  = 1'b0;
    done_c  = 1'b0;
    err_c   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        load_p = 1'b1;
        rem_n  = cnt_prog;
        st_n   = ST_ARB;
      end
      ST_ARB: begin
        if (!en) st_n = ST_IDLE;
        else if (trigger && arb_gnt_i) begin
          if (addr_ok) begin
            ack_set = ~ctrl.m2m;
            st_n    = ST_RD;
          end else begin
            err_c  = 1'b1;
            clr_en = 1'b1;
            st_n   = ST_IDLE;
          end
        end
      end
      ST_RD, ST_WR: if (bus_ready_i) begin
        if (bus_err_i) begin
          err_c   = 1'b1;
          clr_en  = 1'b1;
          ack_clr = 1'b1;
          st_n    = ST_IDLE;
        end else if (st_q == ST_RD) begin
          st_n = ST_WR;
        end else begin
          adv    = 1'b1;
          rem_n  = rem_dec;
          half_c = (rem_dec == (cnt_prog >> 1));
          st_n   = ctrl.m2m ? ST_ARB : ST_ACKW;
          if (rem_q == CW'(1)) begin
            done_c = 1'b1;
            if (circ_eff) begin
              load_p = 1'b1;
              rem_n  = cnt_prog;
            end else begin
              clr_en = 1'b1;
              if (ctrl.m2m) st_n = ST_IDLE;
            end
          end
        end
      end
      ST_ACKW: if (!preq_i) begin
        ack_clr = 1'b1;
        st_n    = en ? ST_ARB : ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      data_q <= '0;
      pack_q <= 1'b0;
      half_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      rem_q  <= rem_n;
      half_q <= half_c;
      done_q <= done_c | zero_done;
      err_q  <= err_c;
      if (ack_set)      pack_q <= 1'b1;
      else if (ack_clr) pack_q <= 1'b0;
      if (st_q == ST_RD && bus_ready_i && !bus_err_i)
        data_q <= bus_rdata_i & DW'(wid_mask(src_wid));
    end
  end

  assign bus_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign bus_we_o    = (st_q == ST_WR);
  assign bus_addr_o  = bus_we_o ? dst_addr : src_addr;
  assign bus_size_o  = bus_we_o ? dst_wid : src_wid;
  assign bus_wdata_o = data_q & DW'(wid_mask(dst_wid));
  assign arb_req_o   = (st_q == ST_ARB) && en && trigger;
  assign pack_o      = pack_q;
  assign chan_en_o   = en;
  assign remain_o    = rem_q;
  assign half_o      = half_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  a_r9_bus_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> is_aligned(bus_addr_o[1:0], bus_size_o));
  a_r1_bus_needs_items: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (remain_o != '0));
  a_r8_ack_covers_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !ctrl.m2m) |-> pack_o);
  a_r8_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACKW && !preq_i) |=> !pack_o);
  a_r10_err_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && done_o));

endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned CW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          chan_en, arb_req, arb_gnt, preq = 1'b0, pack;
  logic [CW-1:0] remain;
  logic          bus_req, bus_we, bus_ready, bus_err;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          half, done, err;
  logic          gnt_ok = 1'b1;
  logic          err_arm = 1'b0;
  logic [AW-1:0] err_addr = '0;

  int n_vec = 0, n_bad = 0;
  int n_done = 0, n_half = 0, n_err = 0;

  typedef struct { logic [AW-1:0] addr; logic [DW-1:0] data; string req; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_seq #(.AW(AW), .DW(DW), .CW(CW)) u_dma_chan_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .chan_en_o(chan_en), .remain_o(remain),
    .arb_req_o(arb_req), .arb_gnt_i(arb_gnt),
    .preq_i(preq), .pack_o(pack),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_size_o(bus_size), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_ready_i(bus_ready), .bus_err_i(bus_err),
    .half_o(half), .done_o(done), .err_o(err)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return (a * 32'h0101_0101) ^ 32'ha5c3_0f69;
  endfunction

  function automatic logic [DW-1:0] msk(input int w);
    return (w == 0) ? 32'hff : (w == 1) ? 32'hffff : 32'hffff_ffff;
  endfunction

  function automatic logic [AW-1:0] ctl(input bit en, input bit dir, input bit pinc,
      input bit minc, input int pw, input int mw, input bit circ, input bit m2m);
    return {22'd0, m2m, circ, 2'(mw), 2'(pw), minc, pinc, dir, en};
  endfunction

  // bus slave: zero-wait, optional error on one address
  assign bus_ready = bus_req;
  assign bus_err   = bus_req && err_arm && (bus_addr == err_addr);
  assign bus_rdata = pat(bus_addr);
  assign arb_gnt   = arb_req && gnt_ok;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input string req, input logic [AW-1:0] src, input int sw,
      input logic [AW-1:0] dst, input int dw);
    exp_t e;
    e.addr = dst;
    e.data = pat(src) & msk(sw) & msk(dw);
    e.req  = req;
    exp_q.push_back(e);
  endtask

  // monitor: scoreboard of write cycles and pulse counters
  always @(negedge clk) begin
    if (rst_ni) begin
      if (done) n_done++;
      if (half) n_half++;
      if (err)  n_err++;
      if (bus_req && bus_we) begin
        if (exp_q.size() == 0) begin
          n_vec++; n_bad++;
          $display("FAIL R1 unexpected write actual=%0h expected=none", bus_addr);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.req, " addr"}, bus_addr, e.addr);
          check({e.req, " data"}, bus_wdata, e.data);
        end
      end
    end
  end

  task automatic cfg_wr(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [AW-1:0] pb, input logic [AW-1:0] mb, input int cnt);
    cfg_wr(2'd0, pb);
    cfg_wr(2'd1, mb);
    cfg_wr(2'd2, AW'(cnt));
  endtask

  task automatic wait_off();
    for (int i = 0; i < 200 && chan_en; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic periph_item(input string req);
    int t;
    @(negedge clk);
    preq = 1'b1;
    t = 0;
    while (!pack && t < 50) begin @(negedge clk); t++; end
    check({req, " ack rise"}, 32'(pack), 32'd1);
    preq = 1'b0;
    t = 0;
    while (pack && t < 50) begin @(negedge clk); t++; end
    check({req, " ack fall"}, 32'(pack), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int d0, h0, e0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset en", 32'(chan_en), 0);
    check("R1 reset bus", 32'(bus_req), 0);
    check("R1 reset remain", 32'(remain), 0);
    check("R8 reset ack", 32'(pack), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R7 R3 R12 m2m word/word, increments on, periph source
    d0 = n_done; h0 = n_half;
    setup(32'h1000, 32'h2000, 4);
    for (int i = 0; i < 4; i++) push("R3", 32'h1000 + 4*i, 2, 32'h2000 + 4*i, 2);
    cfg_wr(2'd3, ctl(1, 0, 1, 1, 2, 2, 0, 1));
    wait_off();
    check("R1 all written", exp_q.size(), 0);
    check("R5 done once", n_done - d0, 1);
    check("R12 half once", n_half - h0, 1);
    check("R5 enable cleared", 32'(chan_en), 0);

    // R4 zero-extension byte -> word
    setup(32'h1101, 32'h2200, 3);
    for (int i = 0; i < 3; i++) push("R4 zext", 32'h1101 + i, 0, 32'h2200 + 4*i, 2);
    cfg_wr(2'd3, ctl(1, 0, 1, 1, 0, 2, 0, 1));
    wait_off();
    check("R4 zext drained", exp_q.size(), 0);

    // R4 truncation word -> half, R2 direction 1 (memory source)
    setup(32'h3300, 32'h4400, 2);
    for (int i = 0; i < 2; i++) push("R2 R4 trunc", 32'h4400 + 4*i, 2, 32'h3300 + 2*i, 1);
    cfg_wr(2'd3, ctl(1, 1, 1, 1, 1, 2, 0, 1));
    wait_off();
    check("R2 drained", exp_q.size(), 0);

    // R8 peripheral mode, fixed peripheral destination, byte truncation
    setup(32'h0040, 32'h3000, 3);
    for (int i = 0; i < 3; i++) push("R8 R3 fixed", 32'h3000 + 4*i, 2, 32'h0040, 0);
    cfg_wr(2'd3, ctl(1, 1, 0, 1, 0, 2, 0, 0));
    repeat (10) @(negedge clk);
    check("R8 no request no access", exp_q.size(), 3);
    check("R8 no ack idle", 32'(pack), 0);
    for (int i = 0; i < 3; i++) periph_item("R8");
    wait_off();
    check("R8 drained", exp_q.size(), 0);
    check("R5 periph stopped", 32'(chan_en), 0);

    // R6 circular peripheral round of 2, five requests
    d0 = n_done; h0 = n_half;
    setup(32'h0100, 32'h0200, 2);
    for (int i = 0; i < 5; i++) push("R6 wrap", 32'h0100 + 4*(i%2), 2, 32'h0200 + 4*(i%2), 2);
    cfg_wr(2'd3, ctl(1, 0, 1, 1, 2, 2, 1, 0));
    for (int i = 0; i < 5; i++) periph_item("R6");
    repeat (3) @(negedge clk);
    check("R6 drained", exp_q.size(), 0);
    check("R6 still enabled", 32'(chan_en), 1);
    check("R6 done per round", n_done - d0, 2);
    check("R12 half per round", n_half - h0, 3);
    check("R6 remain after reload", 32'(remain), 1);
    cfg_wr(2'd3, ctl(0, 0, 1, 1, 2, 2, 1, 0));
    repeat (2) @(negedge clk);
    check("R11 disable accepted", 32'(chan_en), 0);

    // R7 m2m with circular set: one round only
    d0 = n_done;
    setup(32'h1000, 32'h5000, 2);
    for (int i = 0; i < 2; i++) push("R7 no circ", 32'h1000 + 4*i, 2, 32'h5000 + 4*i, 2);
    cfg_wr(2'd3, ctl(1, 0, 1, 1, 2, 2, 1, 1));
    wait_off();
    check("R7 drained", exp_q.size(), 0);
    check("R7 single done", n_done - d0, 1);

    // R5 count zero
    d0 = n_done;
    setup(32'h1000, 32'h2000, 0);
    cfg_wr(2'd3, ctl(1, 0, 1, 1, 2, 2, 0, 1));
    repeat (4) @(negedge clk);
    check("R5 zero done", n_done - d0, 1);
    check("R5 zero not enabled", 32'(chan_en), 0);

    // R9 misaligned word destination
    e0 = n_err; d0 = n_done;
    setup(32'h1000, 32'h2002, 2);
    cfg_wr(2'd3, ctl(1, 0, 1, 1, 2, 2, 0, 1));
    wait_off();
    check("R9 err pulse", n_err - e0, 1);
    check("R9 no done", n_done - d0, 0);
    check("R9 disabled", 32'(chan_en), 0);

    // R10 bus error on second read
    e0 = n_err;
    err_addr = 32'h1004; err_arm = 1'b1;
    setup(32'h1000, 32'h6000, 3);
    push("R10 first item", 32'h1000, 2, 32'h6000, 2);
    cfg_wr(2'd3, ctl(1, 0, 1, 1, 2, 2, 0, 1));
    wait_off();
    err_arm = 1'b0;
    check("R10 drained", exp_q.size(), 0);
    check("R10 err pulse", n_err - e0, 1);
    check("R10 remain held", 32'(remain), 2);
    check("R10 disabled", 32'(chan_en), 0);

    // R11 writes ignored while enabled
    setup(32'h0100, 32'h7000, 2);
    for (int i = 0; i < 2; i++) push("R11 old base", 32'h0100, 2, 32'h7000 + 4*i, 2);
    cfg_wr(2'd3, ctl(1, 0, 0, 1, 2, 2, 0, 0));
    cfg_wr(2'd1, 32'h9000);
    cfg_wr(2'd2, 32'd7);
    check("R11 count kept", 32'(remain), 2);
    for (int i = 0; i < 2; i++) periph_item("R11");
    wait_off();
    check("R11 drained", exp_q.size(), 0);

    // R13 grant withheld
    gnt_ok = 1'b0;
    setup(32'h1000, 32'h8000, 1);
    push("R13 after grant", 32'h1000, 2, 32'h8000, 2);
    cfg_wr(2'd3, ctl(1, 0, 1, 1, 2, 2, 0, 1));
    repeat (10) @(negedge clk);
    check("R13 request raised", 32'(arb_req), 1);
    check("R13 no access", exp_q.size(), 1);
    gnt_ok = 1'b1;
    wait_off();
    check("R13 drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule